// File: doc/BRIEF.md
# Truncated Partial-Product Fraction Multiplier

This block multiplies two unpacked floating-point operands. Each operand has a signed two's-complement fraction mantissa and a signed two's-complement exponent. The mantissa is left-justified, with its sign in the top bit. The block returns a truncated product mantissa and the summed exponent. It does not normalize, round or pack the result; a later stage does that.

A pulse on `start` captures both operands, provided the block is idle. Any negative mantissa is first turned into a magnitude. The sign of the product is tracked separately. Each magnitude is split into three digits, numbered 1 to 3 from the most significant end. The block forms six of the nine digit-by-digit products, one product per clock cycle, and accumulates them. The three lowest-order products contribute only their upper halves, plus a single carry. That carry comes from the sum of their lower halves. The sign is then restored and `done` pulses with the result.

Latency is fixed and does not depend on the data. The result stays on the outputs until the next operation completes.

Top module: `fracmul_top`

## Requirements
- R1: If either input mantissa is zero, the result mantissa and result exponent are both zero.
- R2: A non-zero result is negative exactly when one operand is negative, and a product of two non-negative operands is never negative.
- R3: A negative operand mantissa is replaced by its negation. If the negation is the most negative code (only bit 47 set), the magnitude becomes that code shifted right by one (0x4000_0000_0000) and the operand exponent is raised by one.
- R4: The result exponent is the sum of the two operand exponents, after any R3 adjustment, plus one, modulo 2^10.
- R5: With magnitudes split into digits d1 = bits 47:32, d2 = bits 31:16 and d3 = bits 15:0, the kept magnitude is (a1*b1)·2^16 + a1*b2 + a2*b1 + ⌊a1*b3/2^16⌋ + ⌊a2*b2/2^16⌋ + ⌊a3*b1/2^16⌋ + c. The products a2*b3, a3*b2 and a3*b3 are never formed.
- R6: The carry c is 1 when the sum of the low 16 bits of a1*b3, a2*b2 and a3*b1 is at least 2^16, and 0 otherwise.
- R7: For a product whose sign is negative, the kept magnitude is negated with the same most-negative correction as in R3, and the result exponent is raised by one if that correction applies.
- R8: `start` is accepted only while `busy` is low. `busy` is high from the edge that accepts `start` until `done`. `done` is a one-cycle pulse on the seventh rising edge after the accepting edge.
- R9: `start` while `busy` is high is ignored: the running operation's result and timing are unchanged.
- R10: After reset, `busy`, `done`, `p_mant` and `p_exp` are zero. `p_mant` and `p_exp` change only on a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply with the operands present this cycle |
| a_mant | input | 48 | Multiplicand fraction, two's complement |
| a_exp | input | 10 | Multiplicand exponent, two's complement |
| b_mant | input | 48 | Multiplier fraction, two's complement |
| b_exp | input | 10 | Multiplier exponent, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: result valid and updated |
| p_mant | output | 48 | Truncated product fraction, two's complement |
| p_exp | output | 10 | Product exponent, two's complement |

## Verification
The checker captures the zero and sign status of the operands on the cycle that `start` is accepted. It therefore takes for granted that `a_mant` and `b_mant` are meaningful in that cycle only.

The sign property relies on the kept magnitude staying below a quarter of full scale. This holds for any 48-bit input, because both magnitudes are below one half.

The bench holds reset from time zero and drives `start` and the operands only at falling edges. It presents new operands only together with a start pulse, except in the scenarios that probe R9 and R10. In those scenarios the operands change while no operation can accept them, and the bench watches the outputs.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  localparam int FPM_NDIG   = 3;
  localparam int FPM_NSTEP  = 6;
  localparam int FPM_STEP_W = $clog2(FPM_NSTEP);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } fpm_state_e;

  // Issue order: the three low-order products first (their low halves feed
  // the carry), then the two middle products, then the top product.
  // Digit index 0 is the most significant digit.
  function automatic logic [1:0] sched_a(input logic [FPM_STEP_W-1:0] s);
    case (s)
      3'd0: sched_a = 2'd0;
      3'd1: sched_a = 2'd1;
      3'd2: sched_a = 2'd2;
      3'd3: sched_a = 2'd0;
      3'd4: sched_a = 2'd1;
      default: sched_a = 2'd0;
    endcase
  endfunction

  function automatic logic [1:0] sched_b(input logic [FPM_STEP_W-1:0] s);
    case (s)
      3'd0: sched_b = 2'd2;
      3'd1: sched_b = 2'd1;
      3'd2: sched_b = 2'd0;
      3'd3: sched_b = 2'd1;
      3'd4: sched_b = 2'd0;
      default: sched_b = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fpm_negcorr.sv
module fpm_negcorr #(
  parameter int W = 48
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         bump
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] neg;

  always_comb begin
    neg  = -din;
    dout = din;
    bump = 1'b0;
    if (en) begin
      if (neg == MOST_NEG) begin
        dout = {1'b0, neg[W-1:1]};
        bump = 1'b1;
      end else begin
        dout = neg;
      end
    end
  end
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  busy,
  output logic                  load,
  output logic                  acc_en,
  output logic                  fin,
  output logic [FPM_STEP_W-1:0] step
);
  localparam logic [FPM_STEP_W-1:0] LAST_STEP = FPM_STEP_W'(FPM_NSTEP - 1);

  fpm_state_e state;

  assign busy   = (state != ST_IDLE);
  assign load   = (state == ST_IDLE) && start;
  assign acc_en = (state == ST_RUN);
  assign fin    = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          step  <= '0;
        end
        ST_RUN: begin
          if (step == LAST_STEP) state <= ST_FIN;
          step <= step + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_pp_accum.sv
module fpm_pp_accum
  import fpm_pkg::*;
#(
  parameter int DIG_W = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        en,
  input  logic [FPM_STEP_W-1:0]       step,
  input  logic [FPM_NDIG*DIG_W-1:0]   mag_a,
  input  logic [FPM_NDIG*DIG_W-1:0]   mag_b,
  output logic [FPM_NDIG*DIG_W-1:0]   acc,
  output logic                        carry
);
  localparam int MANT_W = FPM_NDIG * DIG_W;
  localparam int PP_W   = 2 * DIG_W;
  localparam int LO_W   = DIG_W + 2;

  logic [DIG_W-1:0]  da [FPM_NDIG];
  logic [DIG_W-1:0]  db [FPM_NDIG];
  logic [1:0]        ia, ib;
  logic [2:0]        grp;
  logic [PP_W-1:0]   pp;
  logic [MANT_W-1:0] pp_ext;
  logic [LO_W-1:0]   lo_sum;

  for (genvar k = 0; k < FPM_NDIG; k++) begin : g_dig
    assign da[k] = mag_a[MANT_W-1-k*DIG_W -: DIG_W];
    assign db[k] = mag_b[MANT_W-1-k*DIG_W -: DIG_W];
  end

  assign ia     = sched_a(step);
  assign ib     = sched_b(step);
  assign grp    = {1'b0, ia} + {1'b0, ib};
  assign pp     = da[ia] * db[ib];
  assign pp_ext = {{(MANT_W-PP_W){1'b0}}, pp};
  assign carry  = |lo_sum[LO_W-1:DIG_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc    <= '0;
      lo_sum <= '0;
    end else if (en) begin
      case (grp)
        3'd2: begin
          acc    <= acc + (pp_ext >> DIG_W);
          lo_sum <= lo_sum + {2'b00, pp[DIG_W-1:0]};
        end
        3'd1:    acc <= acc + pp_ext;
        default: acc <= acc + (pp_ext << DIG_W);
      endcase
    end
  end
endmodule

// File: rtl/fracmul_top.sv
module fracmul_top
  import fpm_pkg::*;
#(
  parameter int DIG_W = 16,
  parameter int EXP_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [FPM_NDIG*DIG_W-1:0] a_mant,
  input  logic [EXP_W-1:0]          a_exp,
  input  logic [FPM_NDIG*DIG_W-1:0] b_mant,
  input  logic [EXP_W-1:0]          b_exp,
  output logic                      busy,
  output logic                      done,
  output logic [FPM_NDIG*DIG_W-1:0] p_mant,
  output logic [EXP_W-1:0]          p_exp
);
  localparam int MANT_W = FPM_NDIG * DIG_W;

  logic                  load, acc_en, fin;
  logic [FPM_STEP_W-1:0] step;

  logic [MANT_W-1:0] op_m   [2];
  logic [MANT_W-1:0] op_mag [2];
  logic              op_bmp [2];

  logic [MANT_W-1:0] mag_a_r, mag_b_r;
  logic              sign_r, zero_r;
  logic [EXP_W-1:0]  exp_r;

  logic [MANT_W-1:0] acc, kept, res_m;
  logic              carry, res_bmp;

  fpm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .load(load), .acc_en(acc_en), .fin(fin), .step(step)
  );

  assign op_m[0] = a_mant;
  assign op_m[1] = b_mant;

  for (genvar k = 0; k < 2; k++) begin : g_opnd
    fpm_negcorr #(.W(MANT_W)) u_cond (
      .en(op_m[k][MANT_W-1]), .din(op_m[k]),
      .dout(op_mag[k]), .bump(op_bmp[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_a_r <= '0;
      mag_b_r <= '0;
      sign_r  <= 1'b0;
      zero_r  <= 1'b0;
      exp_r   <= '0;
    end else if (load) begin
      mag_a_r <= op_mag[0];
      mag_b_r <= op_mag[1];
      sign_r  <= a_mant[MANT_W-1] ^ b_mant[MANT_W-1];
      zero_r  <= (a_mant == '0) || (b_mant == '0);
      exp_r   <= a_exp + b_exp + EXP_W'(op_bmp[0]) + EXP_W'(op_bmp[1])
                 + EXP_W'(1);
    end
  end

  fpm_pp_accum #(.DIG_W(DIG_W)) u_acc (
    .clk(clk), .rst(rst), .clr(load), .en(acc_en), .step(step),
    .mag_a(mag_a_r), .mag_b(mag_b_r), .acc(acc), .carry(carry)
  );

  assign kept = acc + MANT_W'(carry);

  fpm_negcorr #(.W(MANT_W)) u_restore (
    .en(sign_r), .din(kept), .dout(res_m), .bump(res_bmp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      p_mant <= '0;
      p_exp  <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        if (zero_r) begin
          p_mant <= '0;
          p_exp  <= '0;
        end else begin
          p_mant <= res_m;
          p_exp  <= exp_r + EXP_W'(res_bmp);
        end
      end
    end
  end
endmodule

// File: rtl/fpm_chk.sv
module fpm_chk #(
  parameter int MANT_W = 48,
  parameter int EXP_W  = 10,
  parameter int LAT    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [MANT_W-1:0] a_mant,
  input logic [MANT_W-1:0] b_mant,
  input logic [MANT_W-1:0] p_mant,
  input logic [EXP_W-1:0]  p_exp
);
  logic [4:0] lat_cnt;
  logic       zero_l, sgn_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_cnt <= '0;
      zero_l  <= 1'b0;
      sgn_l   <= 1'b0;
    end else begin
      if (start && !busy) begin
        lat_cnt <= 5'd1;
        zero_l  <= (a_mant == '0) || (b_mant == '0);
        sgn_l   <= a_mant[MANT_W-1] ^ b_mant[MANT_W-1];
      end else if (done) begin
        lat_cnt <= '0;
      end else if (lat_cnt != '0) begin
        lat_cnt <= lat_cnt + 5'd1;
      end
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8 R9
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat_cnt == 5'(LAT)));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(p_mant) || !$stable(p_exp)) |-> done);

  // R1
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && zero_l) |-> (p_mant == '0 && p_exp == '0));

  // R2
  pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !sgn_l) |-> !p_mant[MANT_W-1]);
endmodule

bind fracmul_top fpm_chk #(
  .MANT_W(MANT_W), .EXP_W(EXP_W), .LAT(fpm_pkg::FPM_NSTEP + 2)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .a_mant(a_mant), .b_mant(b_mant), .p_mant(p_mant), .p_exp(p_exp)
);

// File: tb/tb_fracmul_top.sv
`timescale 1ns/1ps
module tb_fracmul_top;
  localparam int MW = 48;
  localparam int EW = 10;

  logic          clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [MW-1:0] a_m = '0, b_m = '0;
  logic [EW-1:0] a_e = '0, b_e = '0;
  logic          busy, done;
  logic [MW-1:0] p_mant;
  logic [EW-1:0] p_exp;

  int checks = 0, errors = 0;

  fracmul_top dut (
    .clk(clk), .rst(rst), .start(start), .a_mant(a_m), .a_exp(a_e),
    .b_mant(b_m), .b_exp(b_e), .busy(busy), .done(done),
    .p_mant(p_mant), .p_exp(p_exp)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void cond(input logic [MW-1:0] m, output logic [MW-1:0] mag,
                               output logic bmp);
    logic [MW-1:0] n;
    n = -m; mag = m; bmp = 1'b0;
    if (m[MW-1]) begin
      if (n == 48'h8000_0000_0000) begin mag = n >> 1; bmp = 1'b1; end
      else mag = n;
    end
  endfunction

  function automatic void model(input logic [MW-1:0] a, input logic [EW-1:0] ea,
                                input logic [MW-1:0] b, input logic [EW-1:0] eb,
                                output logic [MW-1:0] pm, output logic [EW-1:0] pe);
    logic [MW-1:0] ma, mb, k, r;
    logic ba, bb, br;
    logic [15:0] a1, a2, a3, b1, b2, b3;
    logic [31:0] t13, t22, t31;
    logic [17:0] lo;
    cond(a, ma, ba); cond(b, mb, bb);
    {a1, a2, a3} = ma; {b1, b2, b3} = mb;
    t13 = a1 * b3; t22 = a2 * b2; t31 = a3 * b1;
    lo = 18'(t13[15:0]) + 18'(t22[15:0]) + 18'(t31[15:0]);
    k = (48'(a1 * b1) << 16) + 48'(a1 * b2) + 48'(a2 * b1)
        + 48'(t13[31:16]) + 48'(t22[31:16]) + 48'(t31[31:16])
        + ((lo >= 18'h10000) ? 48'd1 : 48'd0);
    if (a[MW-1] ^ b[MW-1]) cond(-k, r, br);
    else begin r = k; br = 1'b0; end
    if (a[MW-1] ^ b[MW-1]) r = (k == '0) ? '0 : -k;
    if (a == '0 || b == '0) begin pm = '0; pe = '0; end
    else begin pm = r; pe = ea + eb + EW'(ba) + EW'(bb) + EW'(1); end
  endfunction

  task automatic run_op(input logic [MW-1:0] a, input logic [EW-1:0] ea,
                        input logic [MW-1:0] b, input logic [EW-1:0] eb,
                        output logic [MW-1:0] pm, output logic [EW-1:0] pe,
                        output int lat);
    @(negedge clk);
    a_m = a; a_e = ea; b_m = b; b_e = eb; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 1;
    check("R8 busy after accept", 64'(busy), 64'd1);
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    pm = p_mant; pe = p_exp;
    @(negedge clk);
    check("R8 done single cycle", 64'(done), 64'd0);
  endtask

  task automatic expect_op(input string req, input logic [MW-1:0] a, input logic [EW-1:0] ea,
                           input logic [MW-1:0] b, input logic [EW-1:0] eb);
    logic [MW-1:0] pm, em; logic [EW-1:0] pe, ee; int lat;
    run_op(a, ea, b, eb, pm, pe, lat);
    model(a, ea, b, eb, em, ee);
    check({req, " mantissa"}, 64'(pm), 64'(em));
    check({req, " exponent"}, 64'(pe), 64'(ee));
    check("R8 latency", 64'(lat), 64'd8);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset busy", 64'(busy), 64'd0);
    check("R10 reset done", 64'(done), 64'd0);
    check("R10 reset mant", 64'(p_mant), 64'd0);
    check("R10 reset exp", 64'(p_exp), 64'd0);
  endtask

  task automatic t_zero();
    logic [MW-1:0] pm; logic [EW-1:0] pe; int lat;
    run_op('0, 10'd12, 48'h4000_0000_0000, 10'd3, pm, pe, lat);
    check("R1 zero a mant", 64'(pm), 64'd0);
    check("R1 zero a exp", 64'(pe), 64'd0);
    run_op(48'hC123_4567_89AB, 10'd5, '0, 10'd7, pm, pe, lat);
    check("R1 zero b mant", 64'(pm), 64'd0);
    check("R1 zero b exp", 64'(pe), 64'd0);
  endtask

  task automatic t_fixed();
    logic [MW-1:0] pm; logic [EW-1:0] pe; int lat;
    // R5 half times half, no carry (R6 c=0)
    run_op(48'h4000_0000_0000, 10'd1, 48'h4000_0000_0000, 10'd1, pm, pe, lat);
    check("R5 half*half mant", 64'(pm), 64'h1000_0000_0000);
    check("R4 half*half exp", 64'(pe), 64'd3);
    // R6 carry of one from low halves, truncation per R5
    run_op(48'h7FFF_FFFF_FFFF, 10'd0, 48'h7FFF_FFFF_FFFF, 10'd0, pm, pe, lat);
    check("R6 max*max mant", 64'(pm), 64'h3FFF_FFFF_FFFD);
    check("R4 max*max exp", 64'(pe), 64'd1);
    // R2 R7 one negative operand
    run_op(48'h8000_0000_0001, 10'd0, 48'h7FFF_FFFF_FFFF, 10'd0, pm, pe, lat);
    check("R7 neg*pos mant", 64'(pm), 64'hC000_0000_0003);
    check("R2 neg*pos exp", 64'(pe), 64'd1);
    // R2 two negatives give a positive
    run_op(48'h8000_0000_0001, 10'd0, 48'h8000_0000_0001, 10'd0, pm, pe, lat);
    check("R2 neg*neg mant", 64'(pm), 64'h3FFF_FFFF_FFFD);
    // R3 most-negative operand
    run_op(48'h8000_0000_0000, 10'd0, 48'h4000_0000_0000, 10'd0, pm, pe, lat);
    check("R3 mostneg mant", 64'(pm), 64'hF000_0000_0000);
    check("R3 mostneg exp", 64'(pe), 64'd2);
    // R4 exponent wraps modulo 2^10
    run_op(48'h4000_0000_0000, 10'd511, 48'h4000_0000_0000, 10'd511, pm, pe, lat);
    check("R4 wrap exp", 64'(pe), 64'h3FF);
    run_op(48'h4000_0000_0000, 10'h3FB, 48'h4000_0000_0000, 10'h3F9, pm, pe, lat);
    check("R4 negative exp", 64'(pe), 64'h3F5);
  endtask

  task automatic t_busy_ignore();
    logic [MW-1:0] em; logic [EW-1:0] ee; int lat;
    model(48'h5555_AAAA_1234, 10'd4, 48'hA987_6543_2100, 10'd9, em, ee);
    @(negedge clk);
    a_m = 48'h5555_AAAA_1234; a_e = 10'd4; b_m = 48'hA987_6543_2100; b_e = 10'd9;
    start = 1'b1;
    @(negedge clk); start = 1'b0; lat = 1;
    @(negedge clk); lat++;
    a_m = 48'h7000_0000_0000; b_m = '0; a_e = 10'd100; start = 1'b1;
    @(negedge clk); lat++; start = 1'b0;
    while (!done && lat < 20) begin @(negedge clk); lat++; end
    check("R9 ignored start mant", 64'(p_mant), 64'(em));
    check("R9 ignored start exp", 64'(p_exp), 64'(ee));
    check("R9 ignored start latency", 64'(lat), 64'd8);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [MW-1:0] pm0; logic [EW-1:0] pe0; int seen;
    pm0 = p_mant; pe0 = p_exp; seen = 0;
    for (int i = 0; i < 6; i++) begin
      a_m = {i[7:0], 40'h12_3456_789A}; b_m = ~a_m; a_e = 10'(i); b_e = 10'(3*i);
      @(negedge clk);
      if (done) seen++;
    end
    check("R10 hold mant", 64'(p_mant), 64'(pm0));
    check("R10 hold exp", 64'(p_exp), 64'(pe0));
    check("R10 no done without start", 64'(seen), 64'd0);
  endtask

  task automatic t_sweep();
    logic [63:0] s;
    logic [MW-1:0] a, b;
    s = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 24; i++) begin
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      a = s[47:0];
      s ^= s << 13; s ^= s >> 7; s ^= s << 17;
      b = s[47:0];
      if (i % 4 == 1) a[15:0] = 16'hFFFF;
      if (i % 4 == 2) b[31:0] = '0;
      expect_op("R5 R6 R7 sweep", a, s[57:48], b, s[9:0]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_fixed();
    t_busy_ignore();
    t_hold();
    t_sweep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule